// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds a real-time clock and calendar as a set of packed-BCD counters: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a century count. It advances one second on each cycle where the one-second enable is high. The enable comes from an oscillator prescaler outside the block. Rollovers ripple through the fields in the same clock cycle. The block knows the length of every month, and it inserts February 29 in any year whose value is a multiple of four. This is correct up to the year 2100.

A host sets the time by pulsing a load strobe together with a full set of BCD values. Bit 7 of the loaded seconds byte is a stop flag that freezes all counting. A frequency-test enable makes the seconds LSB shown on the output invert on each pulse of a second prescaler enable. A 1024 Hz pulse rate on that enable gives a 512 Hz square wave on the LSB.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After a synchronous reset the outputs read 00:00:00, day of week 01, date 01, month 01, year 00, century CENT_INIT (default BCD 20), and the stop flag (bit 7 of the seconds output) is 0.
- R2: All fields are packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. On a tick, seconds advance by one. Seconds step from 59 to 00 and carry into minutes. Minutes step from 59 to 00 and carry into hours.
- R3: Hours step from 23 to 00, and that rollover advances both the day of week and the date.
- R4: Day of week counts from 01 to 07 and steps from 07 back to 01.
- R5: Date steps back to 01 and carries into month after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In February, date wraps after 29 when the BCD year is a multiple of four, with 00 counted as a leap year, and after 28 otherwise.
- R7: Month steps from 12 to 01 and carries into year. Year steps from 99 to 00 and carries into century. Century (6 bits) steps from 39 to 00.
- R8: A load strobe replaces every field with the load inputs on the next clock edge. It takes priority over a tick in the same cycle. The next tick advances from the loaded values.
- R9: While the stored stop flag (loaded through ld_sec[7], shown on sec_o[7]) is 1, ticks change no field.
- R10: While freq_test is 1 and the stop flag is 0, each toggle_tick pulse inverts sec_o[0] relative to the true seconds LSB, one edge later. When freq_test is 0 or the clock is stopped, sec_o[0] shows the true LSB from the next edge on.
- R11: With neither a tick nor a load, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable, one per second |
| toggle_tick | input | 1 | Test-toggle enable (1024 Hz rate gives 512 Hz) |
| freq_test | input | 1 | Frequency-test enable |
| load | input | 1 | Load strobe for all fields |
| ld_sec | input | 8 | Bit 7 stop flag, bits [6:0] BCD seconds |
| ld_min | input | 8 | BCD minutes |
| ld_hour | input | 8 | BCD hours |
| ld_dow | input | 8 | BCD day of week |
| ld_date | input | 8 | BCD date |
| ld_month | input | 8 | BCD month |
| ld_year | input | 8 | BCD year |
| ld_century | input | 6 | BCD century |
| sec_o | output | 8 | Stop flag and BCD seconds (LSB test-toggled) |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| dow_o | output | 8 | BCD day of week |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| century_o | output | 6 | BCD century |

## Verification
Every result is due exactly one rising edge after its stimulus. This holds for a tick, a load, a stop-flag change and a toggle pulse. A full carry from seconds to century also settles within that single edge. The bench drives inputs just after a falling edge and updates its own integer calendar model at the rising edge. It compares all outputs at the next falling edge, so each check samples the state produced by exactly one edge. Directed cases cover each month-length, leap, century and stop corner. A seeded random run of loads, ticks and test pulses exercises the rest.

// File: rtl/calendar_pkg.sv
package calendar_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int FW = 8;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  // field whose rollover enables field i (carry tree)
  function automatic int parent_of(input int i);
    case (i)
      F_DOW, F_DATE: parent_of = F_HOUR;
      F_MON:         parent_of = F_DATE;
      default:       parent_of = (i > 0) ? i - 1 : 0;
    endcase
  endfunction

  function automatic logic [FW-1:0] field_max(input int i);
    case (i)
      F_SEC, F_MIN: field_max = 8'h59;
      F_HOUR:       field_max = 8'h23;
      F_DOW:        field_max = 8'h07;
      F_DATE:       field_max = 8'h31;
      F_MON:        field_max = 8'h12;
      F_YEAR:       field_max = 8'h99;
      default:      field_max = 8'h39;
    endcase
  endfunction

  function automatic logic [FW-1:0] field_min(input int i);
    case (i)
      F_DOW, F_DATE, F_MON: field_min = 8'h01;
      default:              field_min = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] base_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam int DW = 4;

  always_comb begin
    // packed BCD orders like binary, so >= also catches out-of-range loads
    wrap_o = (val_i >= top_i);
    if (wrap_o)
      nxt_o = base_i;
    else if (val_i[DW-1:0] >= 4'd9)
      nxt_o = {val_i[W-1:DW] + 1'b1, {DW{1'b0}}};
    else
      nxt_o = {val_i[W-1:DW], val_i[DW-1:0] + 4'd1};
  end
endmodule

// File: rtl/month_span.sv
module month_span #(
  parameter int W = 8
) (
  input  logic [W-1:0] month_i,
  input  logic [W-1:0] year_i,
  output logic [W-1:0] last_day_o
);
  logic [6:0] year_bin;
  logic       leap;

  assign year_bin = {year_i[6:4], 3'b000} + {3'b000, year_i[7:4], 1'b0} + {3'b000, year_i[3:0]};
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (month_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/test_toggle.sv
module test_toggle (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic step_i,
  output logic flip_o
);
  always_ff @(posedge clk) begin
    if (rst || !enable_i) flip_o <= 1'b0;
    else if (step_i)      flip_o <= ~flip_o;
  end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter #(
  parameter logic [7:0] CENT_INIT = 8'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       toggle_tick,
  input  logic       freq_test,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [5:0] ld_century,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [5:0] century_o
);
  import calendar_pkg::*;
  localparam int NF = NUM_FIELDS;

  logic [FW-1:0] cnt_q [NF];
  logic [FW-1:0] ld_v  [NF];
  logic [FW-1:0] nxt   [NF];
  logic [FW-1:0] lim   [NF];
  logic [NF-1:0] adv;
  logic [NF-1:0] wrap;
  logic          stop_q;
  logic          flip;
  logic [FW-1:0] last_day;

  assign ld_v[F_SEC]  = {1'b0, ld_sec[6:0]};
  assign ld_v[F_MIN]  = ld_min;
  assign ld_v[F_HOUR] = ld_hour;
  assign ld_v[F_DOW]  = ld_dow;
  assign ld_v[F_DATE] = ld_date;
  assign ld_v[F_MON]  = ld_month;
  assign ld_v[F_YEAR] = ld_year;
  assign ld_v[F_CENT] = {2'b00, ld_century};

  month_span #(.W(FW)) u_span (
    .month_i    (cnt_q[F_MON]),
    .year_i     (cnt_q[F_YEAR]),
    .last_day_o (last_day)
  );

  assign adv[0] = tick_1hz & ~stop_q;

  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam int P = parent_of(i);
    localparam logic [FW-1:0] RST_V = (i == F_CENT) ? CENT_INIT : field_min(i);

    if (i > 0) begin : g_carry
      assign adv[i] = adv[P] & wrap[P];
    end

    if (i == F_DATE) begin : g_dyn
      assign lim[i] = last_day;
    end else begin : g_fix
      assign lim[i] = field_max(i);
    end

    bcd_step #(.W(FW)) u_step (
      .val_i  (cnt_q[i]),
      .top_i  (lim[i]),
      .base_i (field_min(i)),
      .nxt_o  (nxt[i]),
      .wrap_o (wrap[i])
    );

    always_ff @(posedge clk) begin
      if (rst)         cnt_q[i] <= RST_V;
      else if (load)   cnt_q[i] <= ld_v[i];
      else if (adv[i]) cnt_q[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       stop_q <= 1'b0;
    else if (load) stop_q <= ld_sec[7];
  end

  test_toggle u_flip (
    .clk      (clk),
    .rst      (rst),
    .enable_i (freq_test & ~stop_q),
    .step_i   (toggle_tick),
    .flip_o   (flip)
  );

  assign sec_o     = {stop_q, cnt_q[F_SEC][6:1], cnt_q[F_SEC][0] ^ flip};
  assign min_o     = cnt_q[F_MIN];
  assign hour_o    = cnt_q[F_HOUR];
  assign dow_o     = cnt_q[F_DOW];
  assign date_o    = cnt_q[F_DATE];
  assign month_o   = cnt_q[F_MON];
  assign year_o    = cnt_q[F_YEAR];
  assign century_o = cnt_q[F_CENT][5:0];
endmodule

// File: rtl/bcd_calendar_counter_chk.sv
module bcd_calendar_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       freq_test,
  input logic       load,
  input logic [7:0] ld_min,
  input logic [7:0] ld_date,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [5:0] century_o
);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_1hz && !load) |=> $stable({sec_o[7:1], min_o, hour_o, dow_o, date_o, month_o, year_o, century_o}));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (min_o == $past(ld_min)) && (date_o == $past(ld_date)));

  // R9
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_o[7] && !load) |=> $stable({sec_o[6:1], min_o, date_o}));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !load && !freq_test && sec_o == 8'h59) |=> (sec_o[6:0] == 7'h00));

  // R3
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    hour_o <= 8'h23);

  // R4
  dow_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dow_o >= 8'h01) && (dow_o <= 8'h07));
endmodule

bind bcd_calendar_counter bcd_calendar_counter_chk u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .freq_test(freq_test), .load(load),
  .ld_min(ld_min), .ld_date(ld_date), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o), .century_o(century_o)
);

// File: tb/bcd_calendar_counter_test.sv
module bcd_calendar_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic tick_1hz = 0, toggle_tick = 0, freq_test = 0, load = 0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_dow = 0, ld_date = 0, ld_month = 0, ld_year = 0;
  logic [5:0] ld_century = 0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic [5:0] century_o;

  int total = 0, bad = 0;
  int e_s, e_mi, e_h, e_dw, e_d, e_mo, e_y, e_c;
  bit e_stop, e_flip;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_counter uut (.*);

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_advance();
    e_s++;
    if (e_s == 60) begin
      e_s = 0; e_mi++;
      if (e_mi == 60) begin
        e_mi = 0; e_h++;
        if (e_h == 24) begin
          e_h = 0;
          e_dw = (e_dw == 7) ? 1 : e_dw + 1;
          e_d++;
          if (e_d > dim(e_mo, e_y)) begin
            e_d = 1; e_mo++;
            if (e_mo > 12) begin
              e_mo = 1; e_y++;
              if (e_y == 100) begin
                e_y = 0;
                e_c = (e_c == 39) ? 0 : e_c + 1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic check_all(input string tag);
    logic [63:0] got, exp;
    got = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, 2'b00, century_o};
    exp = {e_stop, i2b(e_s)[6:1], i2b(e_s)[0] ^ e_flip, i2b(e_mi), i2b(e_h), i2b(e_dw),
           i2b(e_d), i2b(e_mo), i2b(e_y), i2b(e_c)};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: inputs already set after a falling edge
  task automatic cyc(input bit t, input bit tt, input string tag);
    tick_1hz = t; toggle_tick = tt;
    @(posedge clk);
    if (!freq_test || e_stop) e_flip = 0;
    else if (tt) e_flip = ~e_flip;
    if (load) begin
      e_stop = ld_sec[7]; e_s = b2i({1'b0, ld_sec[6:0]}); e_mi = b2i(ld_min); e_h = b2i(ld_hour);
      e_dw = b2i(ld_dow); e_d = b2i(ld_date); e_mo = b2i(ld_month); e_y = b2i(ld_year);
      e_c = b2i({2'b00, ld_century});
    end else if (t && !e_stop) model_advance();
    @(negedge clk);
    load = 0; tick_1hz = 0; toggle_tick = 0;
    check_all(tag);
  endtask

  task automatic set_time(input bit stp, input int s, input int mi, input int h, input int dw,
                          input int d, input int mo, input int y, input int c, input bit t, input string tag);
    load = 1;
    ld_sec = {stp, i2b(s)[6:0]}; ld_min = i2b(mi); ld_hour = i2b(h); ld_dow = i2b(dw);
    ld_date = i2b(d); ld_month = i2b(mo); ld_year = i2b(y); ld_century = i2b(c)[5:0];
    cyc(t, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    e_s = 0; e_mi = 0; e_h = 0; e_dw = 1; e_d = 1; e_mo = 1; e_y = 0; e_c = 20; e_stop = 0; e_flip = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check_all("R1 reset state");
    cyc(0, 0, "R11 idle hold");
    cyc(1, 0, "R2 first second");

    // R8 load wins over tick; R2/R3/R4/R6 non-leap February end
    set_time(0, 58, 59, 23, 7, 28, 2, 23, 20, 1, "R8 load beats tick");
    cyc(1, 0, "R2 second to 59");
    cyc(1, 0, "R3 R4 R6 day rollover non-leap");
    // R6 leap years
    set_time(0, 59, 59, 23, 3, 28, 2, 24, 20, 0, "R8 load");
    cyc(1, 0, "R6 leap year to Feb 29");
    set_time(0, 59, 59, 23, 3, 29, 2, 24, 20, 0, "R8 load");
    cyc(1, 0, "R6 Feb 29 to Mar 01");
    set_time(0, 59, 59, 23, 3, 28, 2, 0, 21, 0, "R8 load");
    cyc(1, 0, "R6 year 00 leap");
    // R5 month lengths
    set_time(0, 59, 59, 23, 1, 30, 4, 5, 20, 0, "R8 load");
    cyc(1, 0, "R5 April 30 wraps");
    set_time(0, 59, 59, 23, 1, 30, 1, 5, 20, 0, "R8 load");
    cyc(1, 0, "R5 January 30 to 31");
    cyc(0, 0, "R11 hold");
    set_time(0, 59, 59, 23, 1, 31, 1, 5, 20, 0, "R8 load");
    cyc(1, 0, "R5 January 31 wraps");
    // R7 full carry and century wrap
    set_time(0, 59, 59, 23, 7, 31, 12, 99, 39, 0, "R8 load");
    cyc(1, 0, "R7 century 39 to 00");
    set_time(0, 59, 59, 23, 7, 31, 12, 99, 20, 0, "R8 load");
    cyc(1, 0, "R7 year 99 into century");
    // R9 stop
    set_time(1, 10, 0, 0, 1, 1, 1, 1, 20, 0, "R9 load stopped");
    freq_test = 1;
    cyc(1, 1, "R9 R10 stopped no count no flip");
    cyc(1, 1, "R9 stopped");
    set_time(0, 10, 0, 0, 1, 1, 1, 1, 20, 0, "R9 restart");
    // R10 frequency test
    cyc(0, 1, "R10 flip");
    cyc(0, 1, "R10 flip back");
    cyc(0, 1, "R10 flip");
    cyc(1, 0, "R10 count under flip");
    freq_test = 0;
    cyc(0, 1, "R10 test off true LSB");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 40) == 0) begin
        int mo, y;
        mo = $urandom_range(1, 12); y = $urandom_range(0, 99);
        set_time(($urandom_range(0, 9) == 0), $urandom_range(0, 59), $urandom_range(0, 59),
                 $urandom_range(0, 23), $urandom_range(1, 7), $urandom_range(1, dim(mo, y)),
                 mo, y, $urandom_range(0, 39), $urandom_range(0, 1), "R8 random load");
      end else begin
        if ($urandom_range(0, 30) == 0) freq_test = ~freq_test;
        cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), "R2 random run");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule